// File: doc/BRIEF.md
# Indirect-Addressed Parallel Host Register Port

This block gives a host processor access to a small bank of control registers over an 8-bit parallel bus. The bus has one bidirectional data path and three active-low controls: a read strobe, a write strobe and an address-select line. The bank is never addressed directly from the pins. The host first performs a write cycle with address-select held low, which loads an internal pointer. Later read or write cycles with address-select held high then reach the register that the pointer names. Reading with address-select low returns the pointer itself.

The host controls are asynchronous to the block clock. They pass through a two-flop synchroniser, and a write takes effect when the synchronised write strobe rises. Two registers in the bank drive the output-channel controls. One holds a separate enable bit for each channel. The other holds a separate power shut-off bit for each channel. The remaining registers are plain 8-bit storage. A synchronous reset returns every register to a known state: all channels disabled and all channels powered down.

Top module: `hostreg_port`

## Requirements
- R1: After reset, ch_enable is 4'b0000, ch_powerdown is 4'b1111 and the pointer reads 0x00.
- R2: A write cycle with host_sel_n low loads all 8 data bits into the pointer and leaves ch_enable and ch_powerdown unchanged. A read cycle with host_sel_n low returns the pointer.
- R3: A write cycle with host_sel_n high stores data into the register the pointer selects. Pointer 0x00 is the enable register: bit i set enables channel i. Pointer 0x01 is the shut-off register: bit i set powers channel i down. Bits [3:0] of these registers appear on ch_enable and ch_powerdown respectively.
- R4: Writing the enable register leaves ch_powerdown unchanged, and writing the shut-off register leaves ch_enable unchanged.
- R5: A read cycle with host_sel_n high returns the selected register. Bits [7:4] of registers 0x00 and 0x01 always read 0. Registers 0x02 and 0x03 store all 8 bits and reset to 0x00.
- R6: A pointer value of NUM_REGS or more (0x04 or more by default) selects nothing. Writes through it change no register, and reads through it return 0x00.
- R7: A data write takes effect only after host_wr_n returns high. While host_wr_n stays low the outputs do not change. They show the new value no later than 4 clock cycles after the rising edge of host_wr_n.
- R8: The block drives host_data only while the synchronised host_rd_n is low. It releases the bus no later than 4 cycles after host_rd_n returns high.
- R9: Data reads and data writes leave the pointer unchanged (no auto-increment).
- R10: Asserting rst at any time restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel_n | input | 1 | Address-select, active low: low selects the pointer, high selects the pointed register |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low; the access is taken when it rises |
| host_data | inout | 8 | Bidirectional host data bus |
| ch_enable | output | 4 | Per-channel enable bits |
| ch_powerdown | output | 4 | Per-channel power shut-off bits |

## Verification
The assertions take several things about the host for granted. The host never asserts both strobes at once. It keeps host_sel_n and the write data steady from before the write strobe falls until a few cycles after it rises. Each strobe stays at one level for several clock cycles. The bench meets all of this by changing inputs only on the falling clock edge and holding each strobe for four cycles. It also holds the select line and data for four cycles after each strobe edge, and leaves idle cycles between accesses. The bench drives host_data only while host_rd_n is high and the block has released the bus.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    localparam int HRP_DW = 8;

    typedef logic [HRP_DW-1:0] hrp_byte_t;

    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_PTR_WR  = 2'd1,
        ACC_DATA_WR = 2'd2
    } hrp_acc_e;

    typedef struct packed {
        hrp_acc_e  kind;
        hrp_byte_t wdata;
    } hrp_req_t;

    localparam int REG_CH_EN = 0;
    localparam int REG_CH_PD = 1;

    // Bits a register keeps; channel-control registers keep one bit per channel.
    function automatic hrp_byte_t reg_mask(int idx, int nch);
        if (idx == REG_CH_EN || idx == REG_CH_PD)
            return hrp_byte_t'((1 << nch) - 1);
        return '1;
    endfunction

    function automatic hrp_byte_t reg_reset_value(int idx, int nch);
        if (idx == REG_CH_PD)
            return reg_mask(idx, nch);
        return '0;
    endfunction

endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[s] <= RST_VAL;
            else if (s == 0)
                stage_q[s] <= d;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hrp_frontend.sv
module hrp_frontend
    import hrp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      host_sel_n,
    input  logic      host_rd_n,
    input  logic      host_wr_n,
    input  hrp_byte_t bus_in,
    output hrp_req_t  req,
    output logic      rd_active,
    output logic      rd_ptr
);

    logic [2:0] ctl_q;
    hrp_byte_t  dat_q;
    logic       wr_prev_q;
    logic       wr_rise;

    hrp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
        .clk (clk),
        .rst (rst),
        .d   ({host_sel_n, host_rd_n, host_wr_n}),
        .q   (ctl_q)
    );

    hrp_sync #(.W(HRP_DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_in),
        .q   (dat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) wr_prev_q <= 1'b1;
        else     wr_prev_q <= ctl_q[0];
    end

    assign wr_rise = ctl_q[0] & ~wr_prev_q;

    always_comb begin
        req.wdata = dat_q;
        if (!wr_rise)
            req.kind = ACC_NONE;
        else if (ctl_q[2])
            req.kind = ACC_DATA_WR;
        else
            req.kind = ACC_PTR_WR;
    end

    assign rd_active = ~ctl_q[1];
    assign rd_ptr    = ~ctl_q[2];

endmodule

// File: rtl/hrp_regbank.sv
module hrp_regbank
    import hrp_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int NUM_CH   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  hrp_req_t          req,
    input  logic              rd_active,
    input  logic              rd_ptr,
    output hrp_byte_t         rdata,
    output logic              bus_oe,
    output logic [NUM_CH-1:0] ch_enable,
    output logic [NUM_CH-1:0] ch_powerdown
);

    hrp_byte_t ptr_q;
    hrp_byte_t regs [NUM_REGS];
    hrp_byte_t sel_val;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (req.kind == ACC_PTR_WR)
            ptr_q <= req.wdata;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam hrp_byte_t MASK = reg_mask(g, NUM_CH);
        localparam hrp_byte_t RSTV = reg_reset_value(g, NUM_CH);
        hrp_byte_t r_q;
        always_ff @(posedge clk) begin
            if (rst)
                r_q <= RSTV;
            else if (req.kind == ACC_DATA_WR && ptr_q == HRP_DW'(g))
                r_q <= req.wdata & MASK;
        end
        assign regs[g] = r_q;
    end

    always_comb begin
        sel_val = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (ptr_q == HRP_DW'(i))
                sel_val = regs[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            bus_oe <= 1'b0;
        end else begin
            bus_oe <= rd_active;
            if (rd_active)
                rdata <= rd_ptr ? ptr_q : sel_val;
        end
    end

    assign ch_enable    = regs[REG_CH_EN][NUM_CH-1:0];
    assign ch_powerdown = regs[REG_CH_PD][NUM_CH-1:0];

endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hrp_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_sel_n,
    input  logic                    host_rd_n,
    input  logic                    host_wr_n,
    inout  wire  [HRP_DW-1:0]       host_data,
    output logic [NUM_CH-1:0]       ch_enable,
    output logic [NUM_CH-1:0]       ch_powerdown
);

    hrp_req_t  req;
    logic      rd_active;
    logic      rd_ptr;
    hrp_byte_t rdata;
    logic      bus_oe;

    hrp_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst        (rst),
        .host_sel_n (host_sel_n),
        .host_rd_n  (host_rd_n),
        .host_wr_n  (host_wr_n),
        .bus_in     (host_data),
        .req        (req),
        .rd_active  (rd_active),
        .rd_ptr     (rd_ptr)
    );

    hrp_regbank #(.NUM_REGS(NUM_REGS), .NUM_CH(NUM_CH)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .rd_active    (rd_active),
        .rd_ptr       (rd_ptr),
        .rdata        (rdata),
        .bus_oe       (bus_oe),
        .ch_enable    (ch_enable),
        .ch_powerdown (ch_powerdown)
    );

    assign host_data = bus_oe ? rdata : 'z;

endmodule

// File: rtl/hrp_chk.sv
module hrp_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              host_rd_n,
    input logic              host_wr_n,
    input logic              bus_oe,
    input logic [NUM_CH-1:0] ch_enable,
    input logic [NUM_CH-1:0] ch_powerdown
);

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 3'd7)
            since_rst <= since_rst + 3'd1;
    end

    // R1 and R10: the first cycle after reset shows the default channel state
    assert_reset_defaults_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ch_enable == '0 && ch_powerdown == '1));

    // R8: the bus is released once the read strobe has been high for a while
    assert_bus_released_R8: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && host_rd_n && $past(host_rd_n) && $past(host_rd_n, 2)
         && $past(host_rd_n, 3)) |-> !bus_oe);

    // R7: no change in the channel controls without a completed write strobe
    assert_no_write_no_change_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && host_wr_n && $past(host_wr_n) && $past(host_wr_n, 2)
         && $past(host_wr_n, 3) && $past(host_wr_n, 4))
        |=> ($stable(ch_enable) && $stable(ch_powerdown)));

    // R4: a single write never moves both channel-control registers
    assert_one_reg_per_write_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd2) |-> ($stable(ch_enable) || $stable(ch_powerdown)));

endmodule

bind hostreg_port hrp_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_rd_n    (host_rd_n),
    .host_wr_n    (host_wr_n),
    .bus_oe       (bus_oe),
    .ch_enable    (ch_enable),
    .ch_powerdown (ch_powerdown)
);

// File: tb/sim_hostreg_port.sv
`timescale 1ns/1ps
module sim_hostreg_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] tb_drv = 8'h00;
    logic       tb_oe = 1'b0;
    wire  [7:0] bus;
    logic [3:0] ch_en;
    logic [3:0] ch_pd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    assign bus = tb_oe ? tb_drv : 'z;

    always #4 clk = ~clk;

    hostreg_port u0 (
        .clk          (clk),
        .rst          (rst),
        .host_sel_n   (sel_n),
        .host_rd_n    (rd_n),
        .host_wr_n    (wr_n),
        .host_data    (bus),
        .ch_enable    (ch_en),
        .ch_powerdown (ch_pd)
    );

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic host_write(logic sel, logic [7:0] val);
        @(negedge clk);
        sel_n = sel; tb_drv = val; tb_oe = 1'b1;
        idle(1);
        wr_n = 1'b0;
        idle(4);
        wr_n = 1'b1;
        idle(4);
        tb_oe = 1'b0; sel_n = 1'b1;
        idle(2);
    endtask

    task automatic host_read(logic sel, output logic [7:0] val);
        @(negedge clk);
        sel_n = sel; tb_oe = 1'b0;
        idle(1);
        rd_n = 1'b0;
        idle(4);
        val = bus;
        rd_n = 1'b1;
        idle(4);
        sel_n = 1'b1;
        idle(2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(2);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        check("R1 ch_enable", {4'h0, ch_en}, 8'h00);
        check("R1 ch_powerdown", {4'h0, ch_pd}, 8'h0F);
        host_read(1'b0, v);
        check("R1 pointer", v, 8'h00);
    endtask

    task automatic t_channel_writes();
        logic [7:0] v;
        host_write(1'b0, 8'h00);
        host_write(1'b1, 8'h05);
        check("R3 enable write", {4'h0, ch_en}, 8'h05);
        check("R4 powerdown kept", {4'h0, ch_pd}, 8'h0F);
        host_write(1'b0, 8'h01);
        host_write(1'b1, 8'h0A);
        check("R3 powerdown write", {4'h0, ch_pd}, 8'h0A);
        check("R4 enable kept", {4'h0, ch_en}, 8'h05);
        host_read(1'b0, v);
        check("R9 pointer after data write", v, 8'h01);
        host_read(1'b1, v);
        check("R5 read powerdown", v, 8'h0A);
    endtask

    task automatic t_pointer_and_readback();
        logic [7:0] v;
        host_write(1'b0, 8'hA6);
        check("R2 ptr write keeps enable", {4'h0, ch_en}, 8'h05);
        check("R2 ptr write keeps powerdown", {4'h0, ch_pd}, 8'h0A);
        host_read(1'b0, v);
        check("R2 pointer full byte", v, 8'hA6);
        host_write(1'b0, 8'h00);
        host_write(1'b1, 8'hFF);
        check("R3 all enabled", {4'h0, ch_en}, 8'h0F);
        host_read(1'b1, v);
        check("R5 upper bits zero", v, 8'h0F);
        host_read(1'b1, v);
        check("R9 repeat read same reg", v, 8'h0F);
        host_write(1'b0, 8'h03);
        host_read(1'b1, v);
        check("R5 scratch reset", v, 8'h00);
        host_write(1'b0, 8'h02);
        host_write(1'b1, 8'hC3);
        host_read(1'b1, v);
        check("R5 scratch full byte", v, 8'hC3);
    endtask

    task automatic t_out_of_range();
        logic [7:0] v;
        host_write(1'b0, 8'h10);
        host_write(1'b1, 8'h77);
        check("R6 enable untouched", {4'h0, ch_en}, 8'h0F);
        check("R6 powerdown untouched", {4'h0, ch_pd}, 8'h0A);
        host_read(1'b1, v);
        check("R6 read zero", v, 8'h00);
        host_write(1'b0, 8'h02);
        host_read(1'b1, v);
        check("R6 scratch untouched", v, 8'hC3);
    endtask

    task automatic t_strobe_timing();
        host_write(1'b0, 8'h00);
        @(negedge clk);
        sel_n = 1'b1; tb_drv = 8'h03; tb_oe = 1'b1;
        idle(1);
        wr_n = 1'b0;
        idle(6);
        check("R7 no change while strobe low", {4'h0, ch_en}, 8'h0F);
        wr_n = 1'b1;
        idle(4);
        check("R7 update after strobe rise", {4'h0, ch_en}, 8'h03);
        tb_oe = 1'b0;
        idle(2);
    endtask

    task automatic t_bus_release();
        logic [7:0] v;
        host_write(1'b0, 8'h00);
        host_read(1'b1, v);
        check("R8 driven on read", v, 8'h03);
        @(negedge clk);
        tb_drv = 8'hA4; tb_oe = 1'b1;
        idle(2);
        check("R8 bus released", bus, 8'hA4);
        tb_oe = 1'b0;
        idle(2);
    endtask

    task automatic t_mid_reset();
        logic [7:0] v;
        host_write(1'b0, 8'h01);
        host_write(1'b1, 8'h00);
        check("R3 all powered up", {4'h0, ch_pd}, 8'h00);
        do_reset();
        check("R10 enable default", {4'h0, ch_en}, 8'h00);
        check("R10 powerdown default", {4'h0, ch_pd}, 8'h0F);
        host_read(1'b0, v);
        check("R10 pointer default", v, 8'h00);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset_state();
        t_channel_writes();
        t_pointer_and_readback();
        t_out_of_range();
        t_strobe_timing();
        t_bus_release();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule